// File: doc/BRIEF.md
# Scan-Driven Flash Page Buffer Byte Loader

This block is a test data register behind a boundary-scan TAP. It is clocked by the test clock and steered by the TAP's Capture-DR, Shift-DR and Update-DR state decodes. An 8-bit shift chain sits between the serial input and the serial output. A separate 8-bit holding register feeds the flash page buffer. Software sets up a starting word address and then shifts only data bytes. The block works out where each byte belongs.

In load mode, every accepted Update-DR copies the shift chain into the holding register. It then starts an 11-cycle write window. During that window the held byte, a word address and a low/high byte select are driven toward the page buffer, together with a one-cycle write strobe. In read mode, each Capture-DR instead loads the selected byte of the flash read data into the shift chain, so that it can be shifted out.

Both modes share one byte sequencer. A mode-entry pulse points it at the low byte of the preset word. Each event then alternates between the low and the high byte. The word counter steps forward only when the sequencer moves on to a new low byte, and never on the first byte. Because of this, filling the last word of a page leaves the counter on that word.

The write sequencer has four states:
- `WS_IDLE`: no window is running.
- `WS_SETUP`: the address and data settle before the strobe.
- `WS_STROBE`: the one-cycle write.
- `WS_RECOVER`: the rest of the window.

Its transitions are:
- IDLE→SETUP on an accepted update.
- SETUP→STROBE when the window counter reaches the cycle before the strobe slot.
- STROBE→RECOVER unconditionally.
- RECOVER→IDLE when the counter reaches the window length.

Top module: `jtag_pgload_dr`

## Requirements
- R1: After reset `tdo`, `busy` and `pb_we` are 0. `pb_we` is never high while `busy` is low.
- R2: While `shift_dr` is high, each rising edge of `tck` shifts `tdi` into bit 7 of the chain and moves the chain one place toward bit 0. `tdo` always shows bit 0, so bytes leave least significant bit first.
- R3: An update accepted in load mode copies the chain into the holding register, which drives `pb_data`. Shifting during the write window does not change the byte that is written.
- R4: An accepted update raises `busy` for exactly 11 cycles, starting with the cycle after the update edge. `pb_we` is high for exactly one cycle, which is the third cycle of that window.
- R5: The first event after a `mode_enter` pulse targets the low byte (`pb_hi` = 0) at the word preset by `addr_load`. Later events alternate high, low, high and so on.
- R6: The word address is incremented before each low-byte event except the first after mode entry. A high byte uses the same word as the low byte before it, so the last word loaded keeps the counter on that word.
- R7: In read mode (`mode_read` = 1), `capture_dr` loads the chain from `rd_data` for the byte selected by `pb_addr`/`pb_hi`. It advances the sequence by the same rules as R5 and R6.
- R8: An update that arrives while `busy` is high is ignored. It causes no extra write and does not advance the byte sequence.
- R9: In read mode `update_dr` produces no write window and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| capture_dr | input | 1 | TAP Capture-DR decode |
| shift_dr | input | 1 | TAP Shift-DR decode |
| update_dr | input | 1 | TAP Update-DR decode |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (chain bit 0) |
| mode_enter | input | 1 | Pulse on entering load or read mode; restarts the byte sequence |
| mode_read | input | 1 | 1 = read-back mode, 0 = page-load mode |
| addr_load | input | 1 | Preset the word counter from `addr_in` |
| addr_in | input | AW | Starting word address |
| rd_data | input | 16 | Flash word being read; the low byte is bits 7:0 |
| pb_addr | output | AW | Word address toward the page buffer or flash |
| pb_hi | output | 1 | Byte select: 0 = low, 1 = high |
| pb_data | output | 8 | Held byte toward the page buffer |
| pb_we | output | 1 | One-cycle page-buffer write strobe |
| busy | output | 1 | Write window in progress |

## Verification
Serial shifting and the page-buffer write window can run in the same cycles. Shifting the next byte straight after an update therefore changes the chain while the strobe is still pending. The bench provokes this by shifting a new byte through the first eight cycles of a window. It judges the result by reading back, from its page-buffer model, the byte and slot written at the strobe. A second overlap places an update inside a running window. The bench judges it by the total number of writes and by the slot that the next accepted byte lands in.

// File: rtl/pgload_pkg.sv
package pgload_pkg;
    typedef enum logic [1:0] {
        WS_IDLE,
        WS_SETUP,
        WS_STROBE,
        WS_RECOVER
    } wr_state_t;

    localparam int BYTE_W = 8;
endpackage

// File: rtl/pgl_shift_chain.sv
module pgl_shift_chain #(
    parameter int W = 8
) (
    input  logic         tck,
    input  logic         rst_n,
    input  logic         cap_en,
    input  logic [W-1:0] cap_data,
    input  logic         shift_en,
    input  logic         tdi,
    output logic [W-1:0] q,
    output logic         tdo
);
    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (cap_en) begin
            q <= cap_data;
        end else if (shift_en) begin
            q <= {tdi, q[W-1:1]};
        end
    end

    assign tdo = q[0];
endmodule

// File: rtl/pgl_byte_seq.sv
module pgl_byte_seq #(
    parameter int AW = 7
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          mode_enter,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic          advance,
    output logic [AW-1:0] sel_addr,
    output logic          sel_hi
);
    logic [AW-1:0] word_q;
    logic          nxt_hi_q;
    logic          first_q;

    // Pre-increment applies only when moving on to a fresh low byte.
    always_comb begin
        sel_hi   = nxt_hi_q;
        sel_addr = (!nxt_hi_q && !first_q) ? word_q + AW'(1) : word_q;
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            nxt_hi_q <= 1'b0;
            first_q  <= 1'b1;
        end else begin
            if (mode_enter) begin
                nxt_hi_q <= 1'b0;
                first_q  <= 1'b1;
            end else if (advance) begin
                nxt_hi_q <= ~nxt_hi_q;
                first_q  <= 1'b0;
            end
            if (addr_load) begin
                word_q <= addr_in;
            end else if (advance && !mode_enter) begin
                word_q <= sel_addr;
            end
        end
    end
endmodule

// File: rtl/pgl_write_fsm.sv
module pgl_write_fsm
    import pgload_pkg::*;
#(
    parameter int WIN       = 11,
    parameter int STROBE_AT = 3
) (
    input  logic tck,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic we
);
    localparam int CW = $clog2(WIN + 1);

    wr_state_t      state_q, state_d;
    logic [CW-1:0]  cyc_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:    if (start) state_d = WS_SETUP;
            WS_SETUP:   if (cyc_q == CW'(STROBE_AT - 1)) state_d = WS_STROBE;
            WS_STROBE:  state_d = WS_RECOVER;
            WS_RECOVER: if (cyc_q == CW'(WIN)) state_d = WS_IDLE;
            default:    state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cyc_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == WS_IDLE) begin
                cyc_q <= start ? CW'(1) : '0;
            end else begin
                cyc_q <= cyc_q + CW'(1);
            end
        end
    end

    always_comb begin
        busy = (state_q != WS_IDLE);
        we   = (state_q == WS_STROBE);
    end
endmodule

// File: rtl/jtag_pgload_dr.sv
module jtag_pgload_dr
    import pgload_pkg::*;
#(
    parameter int AW        = 7,
    parameter int WIN       = 11,
    parameter int STROBE_AT = 3
) (
    input  logic          tck,
    input  logic          rst_n,
    input  logic          capture_dr,
    input  logic          shift_dr,
    input  logic          update_dr,
    input  logic          tdi,
    output logic          tdo,
    input  logic          mode_enter,
    input  logic          mode_read,
    input  logic          addr_load,
    input  logic [AW-1:0] addr_in,
    input  logic [15:0]   rd_data,
    output logic [AW-1:0] pb_addr,
    output logic          pb_hi,
    output logic [7:0]    pb_data,
    output logic          pb_we,
    output logic          busy
);
    logic [BYTE_W-1:0] chain_q;
    logic [BYTE_W-1:0] hold_q;
    logic [AW-1:0]     wr_addr_q;
    logic              wr_hi_q;
    logic [AW-1:0]     sel_addr;
    logic              sel_hi;
    logic              accept_wr;
    logic              accept_rd;
    logic [BYTE_W-1:0] rd_byte;

    assign accept_wr = update_dr && !mode_read && !busy;
    assign accept_rd = capture_dr && mode_read;
    assign rd_byte   = sel_hi ? rd_data[15:8] : rd_data[7:0];

    pgl_shift_chain #(.W(BYTE_W)) u_chain (
        .tck      (tck),
        .rst_n    (rst_n),
        .cap_en   (accept_rd),
        .cap_data (rd_byte),
        .shift_en (shift_dr),
        .tdi      (tdi),
        .q        (chain_q),
        .tdo      (tdo)
    );

    pgl_byte_seq #(.AW(AW)) u_seq (
        .tck        (tck),
        .rst_n      (rst_n),
        .mode_enter (mode_enter),
        .addr_load  (addr_load),
        .addr_in    (addr_in),
        .advance    (accept_wr || accept_rd),
        .sel_addr   (sel_addr),
        .sel_hi     (sel_hi)
    );

    pgl_write_fsm #(.WIN(WIN), .STROBE_AT(STROBE_AT)) u_wr (
        .tck   (tck),
        .rst_n (rst_n),
        .start (accept_wr),
        .busy  (busy),
        .we    (pb_we)
    );

    always_ff @(posedge tck or negedge rst_n) begin
        if (!rst_n) begin
            hold_q    <= '0;
            wr_addr_q <= '0;
            wr_hi_q   <= 1'b0;
        end else if (accept_wr) begin
            hold_q    <= chain_q;
            wr_addr_q <= sel_addr;
            wr_hi_q   <= sel_hi;
        end
    end

    always_comb begin
        pb_data = hold_q;
        pb_addr = busy ? wr_addr_q : sel_addr;
        pb_hi   = busy ? wr_hi_q   : sel_hi;
    end
endmodule

// File: rtl/pgload_chk.sv
module pgload_chk #(
    parameter int AW = 7
) (
    input logic          tck,
    input logic          rst_n,
    input logic          update_dr,
    input logic          mode_read,
    input logic          busy,
    input logic          pb_we,
    input logic [7:0]    pb_data,
    input logic [AW-1:0] pb_addr,
    input logic          pb_hi
);
    // R1: the strobe only ever appears inside a window
    p_we_in_window_r1: assert property (@(posedge tck) disable iff (!rst_n)
        pb_we |-> busy);

    // R4: the strobe lasts one cycle
    p_single_strobe_r4: assert property (@(posedge tck) disable iff (!rst_n)
        pb_we |=> !pb_we);

    // R4: an accepted load update opens a window on the next cycle
    p_window_opens_r4: assert property (@(posedge tck) disable iff (!rst_n)
        (update_dr && !mode_read && !busy) |=> busy);

    // R9: a window can only follow a load-mode update
    p_window_cause_r9: assert property (@(posedge tck) disable iff (!rst_n)
        $rose(busy) |-> ($past(update_dr) && !$past(mode_read)));

    // R3: the held byte is frozen for the whole window
    p_data_frozen_r3: assert property (@(posedge tck) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(pb_data));

    // R8: target slot cannot move while a window runs
    p_slot_frozen_r8: assert property (@(posedge tck) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(pb_addr) && $stable(pb_hi)));
endmodule

bind jtag_pgload_dr pgload_chk #(.AW(AW)) u_pgload_chk (
    .tck       (tck),
    .rst_n     (rst_n),
    .update_dr (update_dr),
    .mode_read (mode_read),
    .busy      (busy),
    .pb_we     (pb_we),
    .pb_data   (pb_data),
    .pb_addr   (pb_addr),
    .pb_hi     (pb_hi)
);

// File: tb/tb_jtag_pgload_dr.sv
module tb_jtag_pgload_dr;
    localparam int PERIOD = 10;
    localparam int AW     = 7;
    localparam int NVEC   = 6;
    localparam logic [7:0] LOAD_VEC [NVEC] = '{8'h5A, 8'hC1, 8'h0F, 8'h96, 8'h81, 8'h3E};

    logic          tck = 1'b0;
    logic          rst_n = 1'b0;
    logic          capture_dr = 1'b0;
    logic          shift_dr = 1'b0;
    logic          update_dr = 1'b0;
    logic          tdi = 1'b0;
    logic          tdo;
    logic          mode_enter = 1'b0;
    logic          mode_read = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [15:0]   rd_data;
    logic [AW-1:0] pb_addr;
    logic          pb_hi;
    logic [7:0]    pb_data;
    logic          pb_we;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic [7:0]    mem_lo [2**AW];
    logic [7:0]    mem_hi [2**AW];
    int            wr_count = 0;
    logic [AW-1:0] last_addr;
    logic          last_hi;
    logic [7:0]    last_data;

    always #(PERIOD/2) tck = ~tck;

    jtag_pgload_dr #(.AW(AW)) dut (
        .tck(tck), .rst_n(rst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
        .update_dr(update_dr), .tdi(tdi), .tdo(tdo), .mode_enter(mode_enter),
        .mode_read(mode_read), .addr_load(addr_load), .addr_in(addr_in),
        .rd_data(rd_data), .pb_addr(pb_addr), .pb_hi(pb_hi), .pb_data(pb_data),
        .pb_we(pb_we), .busy(busy)
    );

    // Page buffer / flash model
    assign rd_data = {mem_hi[pb_addr], mem_lo[pb_addr]};

    always @(posedge tck) begin
        if (pb_we) begin
            if (pb_hi) mem_hi[pb_addr] <= pb_data;
            else       mem_lo[pb_addr] <= pb_data;
            last_addr <= pb_addr;
            last_hi   <= pb_hi;
            last_data <= pb_data;
            wr_count  <= wr_count + 1;
        end
    end

    function automatic logic [7:0] pattern(input int w, input int h);
        return 8'((w * 2 + h) ^ 8'hA5);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic step();
        @(negedge tck);
    endtask

    task automatic enter_mode(input logic rd, input int addr);
        mode_read  = rd;
        mode_enter = 1'b1;
        addr_load  = 1'b1;
        addr_in    = AW'(addr);
        step();
        mode_enter = 1'b0;
        addr_load  = 1'b0;
    endtask

    task automatic shift_byte(input logic [7:0] b, output logic [7:0] out);
        for (int i = 0; i < 8; i++) begin
            out[i]   = tdo;
            tdi      = b[i];
            shift_dr = 1'b1;
            step();
        end
        shift_dr = 1'b0;
    endtask

    task automatic pulse_update();
        update_dr = 1'b1;
        step();
        update_dr = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] outb;
        logic [7:0] prev;
        int base;
        int busy_n;
        int we_at;
        int wc0;

        for (int w = 0; w < 2**AW; w++) begin
            mem_lo[w] = pattern(w, 0);
            mem_hi[w] = pattern(w, 1);
        end

        step();
        step();
        // R1: reset state
        chk(tdo == 1'b0 && busy == 1'b0 && pb_we == 1'b0, "R1 reset outputs",
            {tdo, busy, pb_we}, 0);
        rst_n = 1'b1;
        step();

        // Table-driven page load: R2, R3, R5, R6
        base = 40;
        enter_mode(1'b0, base);
        prev = '0;
        for (int i = 0; i < NVEC; i++) begin
            shift_byte(LOAD_VEC[i], outb);
            if (i > 0)
                chk(outb == prev, "R2 tdo shifts previous byte LSB first", outb, prev);
            pulse_update();
            wait_cycles(12);
            chk(wr_count == i + 1, "R3 one write per update", wr_count, i + 1);
            chk(last_data == LOAD_VEC[i], "R3 written byte", last_data, LOAD_VEC[i]);
            chk(last_hi == 1'(i % 2), "R5 byte alternation", last_hi, i % 2);
            chk(int'(last_addr) == base + i / 2, "R6 word pre-increment", last_addr, base + i / 2);
            prev = LOAD_VEC[i];
        end

        // R4 window timing with overlapped shifting (R3)
        enter_mode(1'b0, 60);
        shift_byte(8'h3C, outb);
        pulse_update();
        busy_n = 0;
        we_at  = 0;
        for (int j = 1; j <= 12; j++) begin
            if (busy) busy_n++;
            if (pb_we) we_at = (we_at == 0) ? j : -1;
            if (j <= 8) begin
                tdi      = j[0];
                shift_dr = 1'b1;
            end else begin
                shift_dr = 1'b0;
            end
            step();
        end
        shift_dr = 1'b0;
        chk(busy_n == 11, "R4 busy window length", busy_n, 11);
        chk(we_at == 3, "R4 strobe cycle in window", we_at, 3);
        chk(mem_lo[60] == 8'h3C, "R3 overlap shift keeps held byte", mem_lo[60], 8'h3C);
        chk(last_addr == AW'(60) && last_hi == 1'b0, "R5 first byte low at preset",
            {last_addr, last_hi}, 120);

        // R8: update inside a running window is dropped
        shift_byte(8'h77, outb);
        pulse_update();
        wc0 = wr_count;
        step();
        pulse_update();
        wait_cycles(12);
        chk(wr_count == wc0 + 1, "R8 no extra write", wr_count, wc0 + 1);
        chk(mem_hi[60] == 8'h77, "R8 accepted byte high at 60", mem_hi[60], 8'h77);
        shift_byte(8'h12, outb);
        pulse_update();
        wait_cycles(12);
        chk(last_addr == AW'(61) && last_hi == 1'b0, "R8 sequence not advanced",
            {last_addr, last_hi}, 122);

        // R6: last word of the address space stays put for its high byte
        enter_mode(1'b0, 2**AW - 1);
        shift_byte(8'hE4, outb);
        pulse_update();
        wait_cycles(12);
        shift_byte(8'h4E, outb);
        pulse_update();
        wait_cycles(12);
        chk(mem_lo[2**AW-1] == 8'hE4 && mem_hi[2**AW-1] == 8'h4E, "R6 last word both bytes",
            {mem_hi[2**AW-1], mem_lo[2**AW-1]}, 16'h4EE4);
        chk(int'(last_addr) == 2**AW - 1, "R6 high byte stays on last word", last_addr, 2**AW - 1);

        // R7: read-back with the same sequencing
        for (int w = 20; w < 22; w++) begin
            mem_lo[w] = pattern(w, 0);
            mem_hi[w] = pattern(w, 1);
        end
        enter_mode(1'b1, 20);
        wc0 = wr_count;
        for (int k = 0; k < 4; k++) begin
            capture_dr = 1'b1;
            step();
            capture_dr = 1'b0;
            shift_byte(8'h00, outb);
            chk(outb == pattern(20 + k / 2, k % 2), "R7 read-back byte", outb,
                pattern(20 + k / 2, k % 2));
        end

        // R9: update in read mode does nothing
        pulse_update();
        chk(busy == 1'b0, "R9 no window in read mode", busy, 0);
        wait_cycles(12);
        chk(wr_count == wc0, "R9 no write in read mode", wr_count, wc0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule